// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences a processor's sleep states. Software writes a control word whose two-bit sleep field selects one of three depths. The field only takes effect when the CPU reports that it has executed its idle instruction. At that point the block drops the clock enables that the chosen depth switches off. The five enables are the CPU clock, the system/peripheral clock, the watchdog clock, the PLL and the oscillator.

The block then waits for a wake source that the current depth accepts. The light idle accepts peripheral interrupts, external interrupt pins and device reset. The deep idle accepts wakeup-class interrupts, external pins and device reset. Halt accepts device reset only. The power-drive-protection input counts as an external pin.

In deep idle, an external pin raises the CPU and system enables through a combinational path, with no clock edge needed. Leaving halt first restarts the oscillator and waits a parameterised number of reference cycles. After that wait, all clocks come back and the CPU reset sequence is started. Any rising edge on an external pin outside halt is passed through a two-flop synchronizer, which runs only while the system clock is enabled. The synchronizer output becomes a one-cycle interrupt request.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After controller reset `rst`, all five enables are 1, `cpu_rst_start` and `irq_req` are 0, and the stored sleep field is 00.
- R2: A write loads bits 13:12 of `cfg_wdata` as the sleep field. The write alone leaves every enable unchanged. The field is used at the next `idle_req` seen in the running state.
- R3: `idle_req` with field 00 clears `cpu_clk_en` at that clock edge. The other four enables stay 1.
- R4: In light idle, `periph_irq` or any external source (a pin or `pdp_irq`) restores all enables at the next edge. `wake_irq` is ignored.
- R5: `idle_req` with field 01 clears `cpu_clk_en` and `sys_clk_en`. The watchdog, PLL and oscillator enables stay 1.
- R6: In deep idle, `wake_irq` restores all enables at the next edge. `periph_irq` is ignored.
- R7: In deep idle, a high external pin drives `cpu_clk_en` and `sys_clk_en` to 1 combinationally, before any clock edge. The next edge returns the block to running.
- R8: `idle_req` with field 10 or 11 clears all five enables. Peripheral, wakeup and external inputs then have no effect.
- R9: `dev_rst` during halt sets only `osc_en` at that edge. After `OSC_CYCLES` further edges, all enables return to 1 together with a one-cycle `cpu_rst_start`.
- R10: `dev_rst` in running, light idle or deep idle gives all enables 1 and a one-cycle `cpu_rst_start` at the next edge.
- R11: A rising edge of any external source outside halt gives exactly one `irq_req` pulse, high after the third edge following the edge that sampled it. Holding the source high gives no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high controller reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W | Control word; sleep field at bits 13:12 |
| idle_req | input | 1 | CPU executed the idle instruction |
| dev_rst | input | 1 | Device reset request from any source |
| periph_irq | input | 1 | Peripheral interrupt (light idle wake) |
| wake_irq | input | 1 | Wakeup-class interrupt (deep idle wake) |
| ext_pin | input | N_EXT | External interrupt pins |
| pdp_irq | input | 1 | Power-drive-protection interrupt, treated as external |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| sys_clk_en | output | 1 | System/peripheral clock domain enable |
| wd_clk_en | output | 1 | Watchdog clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_rst_start | output | 1 | One-cycle start of the CPU reset sequence |
| irq_req | output | 1 | One-cycle external interrupt request |

## Verification
A wrong state register shows up at the enable outputs on the very edge that follows the fault. All five enables are a direct decode of the state, so a light idle mistaken for a deep idle shows up as a wrong `sys_clk_en` within one cycle. A fault in the start-up counter moves the release edge of the enables and of `cpu_rst_start` away from exactly `OSC_CYCLES` edges after the reset request. A fault in the synchronizer shifts, drops or repeats the `irq_req` pulse, which is visible from the third edge after the pin rises.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE1 = 3'd1,
    ST_IDLE2 = 3'd2,
    ST_HALT  = 3'd3,
    ST_OSCW  = 3'd4
  } lpm_state_e;

  // enable vector order: {cpu, sys, wd, pll, osc}
  function automatic logic [4:0] en_for(lpm_state_e s);
    case (s)
      ST_RUN:   en_for = 5'b11111;
      ST_IDLE1: en_for = 5'b01111;
      ST_IDLE2: en_for = 5'b00111;
      ST_OSCW:  en_for = 5'b00001;
      default:  en_for = 5'b00000;
    endcase
  endfunction

  function automatic lpm_state_e sleep_for(logic [1:0] field);
    if (field[1])       sleep_for = ST_HALT;
    else if (field[0])  sleep_for = ST_IDLE2;
    else                sleep_for = ST_IDLE1;
  endfunction
endpackage

// File: rtl/lpm_wake_decode.sv
module lpm_wake_decode
  import lpm_pkg::*;
(
  input  lpm_state_e st,
  input  logic       periph_irq,
  input  logic       wake_irq,
  input  logic       ext_any,
  output logic       wake_now,
  output logic       async_wake
);
  always_comb begin
    wake_now   = 1'b0;
    async_wake = 1'b0;
    case (st)
      ST_IDLE1: wake_now = periph_irq | ext_any;
      ST_IDLE2: begin
        wake_now   = wake_irq | ext_any;
        async_wake = ext_any;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_osc_timer.sv
module lpm_osc_timer #(
  parameter int OSC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(OSC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OSC_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/lpm_ext_sync.sv
module lpm_ext_sync (
  input  logic clk,
  input  logic rst,
  input  logic ext_any,
  input  logic armed,
  input  logic adv,
  output logic irq
);
  logic prev_q, pend_q, s1_q, s2_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= ext_any;
      irq_q  <= 1'b0;
      if (s2_q) begin
        irq_q  <= 1'b1;
        pend_q <= 1'b0;
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
      end else begin
        if (ext_any && !prev_q && armed) pend_q <= 1'b1;
        if (adv) begin
          s1_q <= pend_q;
          s2_q <= s1_q;
        end
      end
    end
  end

  assign irq = irq_q;

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  assert_irq_follows_sync_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(s2_q));
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int MODE_LSB   = 12,
  parameter int N_EXT      = 4,
  parameter int OSC_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             idle_req,
  input  logic             dev_rst,
  input  logic             periph_irq,
  input  logic             wake_irq,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic             pdp_irq,
  output logic             cpu_clk_en,
  output logic             sys_clk_en,
  output logic             wd_clk_en,
  output logic             pll_en,
  output logic             osc_en,
  output logic             cpu_rst_start,
  output logic             irq_req
);
  localparam int MODE_MSB = MODE_LSB + 1;

  lpm_state_e st_q, st_d;
  logic [1:0] mode_q;
  logic [4:0] en_q;
  logic       rstart_q, rstart_d;
  logic       ext_any, wake_now, async_wake, osc_done;

  assign ext_any = (|ext_pin) | pdp_irq;

  lpm_wake_decode u_wake (
    .st(st_q), .periph_irq(periph_irq), .wake_irq(wake_irq),
    .ext_any(ext_any), .wake_now(wake_now), .async_wake(async_wake)
  );

  lpm_osc_timer #(.OSC_CYCLES(OSC_CYCLES)) u_osc (
    .clk(clk), .rst(rst), .run(st_q == ST_OSCW), .done(osc_done)
  );

  lpm_ext_sync u_sync (
    .clk(clk), .rst(rst), .ext_any(ext_any),
    .armed((st_q != ST_HALT) && (st_q != ST_OSCW)),
    .adv(en_q[3]), .irq(irq_req)
  );

  always_comb begin
    st_d     = st_q;
    rstart_d = 1'b0;
    if (dev_rst) begin
      case (st_q)
        ST_HALT: st_d = ST_OSCW;
        ST_OSCW: st_d = ST_OSCW;
        default: begin
          st_d     = ST_RUN;
          rstart_d = 1'b1;
        end
      endcase
    end else begin
      case (st_q)
        ST_RUN:   if (idle_req) st_d = sleep_for(mode_q);
        ST_IDLE1,
        ST_IDLE2: if (wake_now) st_d = ST_RUN;
        ST_OSCW:  if (osc_done) begin
          st_d     = ST_RUN;
          rstart_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      mode_q   <= 2'b00;
      en_q     <= 5'b11111;
      rstart_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      en_q     <= en_for(st_d);
      rstart_q <= rstart_d;
      if (cfg_wr) mode_q <= cfg_wdata[MODE_MSB:MODE_LSB];
    end
  end

  assign cpu_clk_en    = en_q[4] | async_wake;
  assign sys_clk_en    = en_q[3] | async_wake;
  assign wd_clk_en     = en_q[2];
  assign pll_en        = en_q[1];
  assign osc_en        = en_q[0];
  assign cpu_rst_start = rstart_q;

  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rstart_q |=> !rstart_q);
  assert_rst_clocks_on_R10: assert property (@(posedge clk) disable iff (rst)
    rstart_q |-> (en_q == 5'b11111));
  assert_idle1_sys_on_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE1) |-> (en_q[3] && !en_q[4]));
  assert_idle2_wd_on_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE2) |-> (en_q[2:0] == 3'b111 && en_q[4:3] == 2'b00));
  assert_wake1_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE1 && (periph_irq || ext_any)) |=> en_q[4]);
  assert_halt_stays_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && !dev_rst) |=> (en_q == 5'b00000));
  assert_halt_exit_osc_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HALT && dev_rst) |=> (en_q == 5'b00001));
endmodule

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
  localparam int N_EXT = 4;
  localparam int OSC_N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, idle_req = 0, dev_rst = 0, periph_irq = 0, wake_irq = 0, pdp_irq = 0;
  logic [15:0] cfg_wdata = '0;
  logic [N_EXT-1:0] ext_pin = '0;
  logic cpu_clk_en, sys_clk_en, wd_clk_en, pll_en, osc_en, cpu_rst_start, irq_req;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  lpm_clk_ctrl #(.N_EXT(N_EXT), .OSC_CYCLES(OSC_N)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .idle_req(idle_req), .dev_rst(dev_rst), .periph_irq(periph_irq),
    .wake_irq(wake_irq), .ext_pin(ext_pin), .pdp_irq(pdp_irq),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .wd_clk_en(wd_clk_en),
    .pll_en(pll_en), .osc_en(osc_en), .cpu_rst_start(cpu_rst_start), .irq_req(irq_req)
  );

  function automatic logic [4:0] en();
    return {cpu_clk_en, sys_clk_en, wd_clk_en, pll_en, osc_en};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_mode(logic [1:0] m);
    cfg_wr = 1; cfg_wdata = 16'h0A5A; cfg_wdata[13:12] = m;
    tick(); cfg_wr = 0;
  endtask

  task automatic enter(logic [1:0] m);
    write_mode(m);
    idle_req = 1; tick(); idle_req = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) tick();
  endtask

  task automatic t_reset();
    chk("R1 enables", en(), 5'b11111);
    chk("R1 rst_start", cpu_rst_start, 0);
    chk("R1 irq", irq_req, 0);
    idle_req = 1; tick(); idle_req = 0;
    chk("R1 field 00 default", en(), 5'b01111);
    periph_irq = 1; tick(); periph_irq = 0;
  endtask

  task automatic t_cfg();
    write_mode(2'b10);
    chk("R2 write alone", en(), 5'b11111);
    tick();
    chk("R2 still running", en(), 5'b11111);
    write_mode(2'b01);
    idle_req = 1; tick(); idle_req = 0;
    chk("R2 last write used", en(), 5'b00111);
    wake_irq = 1; tick(); wake_irq = 0;
  endtask

  task automatic t_idle1();
    enter(2'b00);
    chk("R3 idle1 enables", en(), 5'b01111);
    wake_irq = 1; tick(); wake_irq = 0;
    chk("R4 wake_irq ignored", en(), 5'b01111);
    periph_irq = 1; tick(); periph_irq = 0;
    chk("R4 periph wake", en(), 5'b11111);
    enter(2'b00);
    pdp_irq = 1; tick(); pdp_irq = 0;
    chk("R4 pdp wake", en(), 5'b11111);
    drain();
  endtask

  task automatic t_idle2();
    enter(2'b01);
    chk("R5 idle2 enables", en(), 5'b00111);
    periph_irq = 1; tick(); periph_irq = 0;
    chk("R6 periph ignored", en(), 5'b00111);
    wake_irq = 1; tick(); wake_irq = 0;
    chk("R6 wake_irq wake", en(), 5'b11111);
    chk("R6 no irq from wake", irq_req, 0);
  endtask

  task automatic t_async();
    enter(2'b01);
    ext_pin[2] = 1; #1;
    chk("R7 cpu comb", cpu_clk_en, 1);
    chk("R7 sys comb", sys_clk_en, 1);
    tick();
    chk("R7 registered run", en(), 5'b11111);
    chk("R11 irq e0", irq_req, 0);
    tick(); chk("R11 irq e1", irq_req, 0);
    tick(); chk("R11 irq e2", irq_req, 0);
    tick(); chk("R11 irq e3", irq_req, 1);
    tick(); chk("R11 irq e4", irq_req, 0);
    for (int i = 0; i < 5; i++) begin
      tick(); chk("R11 held no repeat", irq_req, 0);
    end
    ext_pin = '0; drain();
  endtask

  task automatic t_halt();
    enter(2'b11);
    chk("R8 halt enables", en(), 5'b00000);
    periph_irq = 1; wake_irq = 1; ext_pin[0] = 1; pdp_irq = 1;
    tick(); tick();
    periph_irq = 0; wake_irq = 0; ext_pin = '0; pdp_irq = 0;
    chk("R8 sources ignored", en(), 5'b00000);
    for (int i = 0; i < 5; i++) tick();
    chk("R8 no irq in halt", irq_req, 0);
    dev_rst = 1; tick(); dev_rst = 0;
    chk("R9 osc first", en(), 5'b00001);
    chk("R9 no start yet", cpu_rst_start, 0);
    for (int k = 1; k < OSC_N; k++) tick();
    chk("R9 still waiting", en(), 5'b00001);
    tick();
    chk("R9 released", en(), 5'b11111);
    chk("R9 start pulse", cpu_rst_start, 1);
    tick();
    chk("R9 pulse one cycle", cpu_rst_start, 0);
    enter(2'b10);
    chk("R8 field 10 halts", en(), 5'b00000);
    dev_rst = 1; tick(); dev_rst = 0;
    for (int k = 0; k < OSC_N; k++) tick();
    chk("R9 second exit", en(), 5'b11111);
  endtask

  task automatic t_dev_rst();
    enter(2'b01);
    dev_rst = 1; tick(); dev_rst = 0;
    chk("R10 idle2 reset", en(), 5'b11111);
    chk("R10 pulse", cpu_rst_start, 1);
    tick(); chk("R10 pulse end", cpu_rst_start, 0);
    dev_rst = 1; tick(); dev_rst = 0;
    chk("R10 running reset", cpu_rst_start, 1);
    chk("R10 running enables", en(), 5'b11111);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_cfg();
    t_idle1();
    t_idle2();
    t_async();
    t_halt();
    t_dev_rst();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule